// File: doc/BRIEF.md
# Receive Ring Page Writer

This block takes frames that have already passed address filtering and stores them in a circular receive area of a local byte memory. The area is divided into 256-byte pages. The ring runs from a start page up to, but not including, a stop page. The block keeps the current-page pointer. The host may load that pointer while the block is idle, and the block exposes it for reading.

A frame is offered as a length plus a one-cycle request. While the frame is being stored, the block fetches the frame's bytes by index from the frame source. It writes one byte per cycle, page by page, starting four bytes into the frame's first page. Those four bytes are left free for a header. Before it starts each page, the block checks that page against the boundary page, which the host has not yet consumed. If the two match, the frame is dropped whole, the current pointer returns to the frame's first page, and an overrun pulse is raised.

When every byte is stored, the block writes a four-byte header into the first page and raises a receive-ok pulse. The header holds a status byte, the next-frame page and the stored length.

Top module: `rx_ring_writer`

## Requirements
- R1: After synchronous reset, `busy`, `rx_ok`, `ovr` and `mem_we` are low, `cur_page` is 0 and `rsr` is 0x00.
- R2: Each frame byte is written in its own cycle, in index order. Byte i of the first page goes to page `cur_page`, offset i+4. `mem_addr` is the 16-bit value {page, offset} truncated to its low 15 bits. Later bytes continue at offset 0 of each following page. Trailing bytes after the last data byte are not written.
- R3: Each time a page is finished, the current page is incremented. If the new value equals `pg_stop`, it is replaced by `pg_start`.
- R4: After the data, the block writes four bytes at offsets 0..3 of the first page. Offset 0 holds 0x01. Offset 1 holds the current page after the frame. Offset 2 holds the low byte and offset 3 the high byte of the frame length plus 4.
- R5: In the cycle after the last header write, `rx_ok` is high for exactly one cycle and `busy` is low.
- R6: Before a page is written, the block compares the current page with `pg_bound`. If they are equal, the frame is abandoned. No further writes and no header follow, `cur_page` goes back to the frame's first page, and `ovr` pulses for one cycle in the cycle after the compare. `rx_ok` and `ovr` are never high together.
- R7: While `stopped` is high, a frame request is ignored: `busy` stays low and nothing is written.
- R8: `busy` is high from the cycle after a frame is accepted until the frame finishes or is abandoned. Requests made while it is high are ignored.
- R9: A `cur_wr_en` load takes effect only while `busy` is low. If the load coincides with accepting a frame, that frame starts at the loaded page.
- R10: A frame of length 0 uses one page and produces only the header, with a length field of 4.
- R11: `rsr` becomes 0x01 in the same cycle as `rx_ok`, and an abandoned frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stopped | input | 1 | Controller is stopped; new frames are refused |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Page one past the end of the ring |
| pg_bound | input | 8 | Page not yet consumed by the host |
| cur_wr_en | input | 1 | Load the current-page pointer |
| cur_wr_val | input | 8 | Value to load |
| cur_page | output | 8 | Current-page pointer |
| frm_valid | input | 1 | Frame request |
| frm_len | input | 16 | Frame length in bytes |
| dat_req | output | 1 | Frame byte fetched this cycle |
| dat_idx | output | 16 | Index of the fetched byte |
| dat_byte | input | 8 | Frame byte at `dat_idx`, same cycle |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 15 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Frame in progress |
| rx_ok | output | 1 | Frame stored pulse |
| ovr | output | 1 | Frame abandoned on boundary pulse |
| rsr | output | 8 | Receive status value |

## Verification
The sharpest collision in this block occurs when a page rollover lands on `pg_start` in the same step that the boundary compare is due. To provoke it, the boundary is set to the ring start and a long frame is sent from one page past it, so the frame wraps onto the boundary page. The expected outcome is an overrun pulse, no header and a pointer restored to the first page. A second collision is a host pointer load in the very cycle a frame is accepted, which must place that frame at the loaded page. A cycle-by-cycle queue model judges every write address, data byte, pulse and busy cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int PG_W    = 8;
    localparam int OFF_W   = 8;
    localparam int MEM_AW  = 15;
    localparam int LEN_W   = 16;
    localparam int HDR_LEN = 4;
    localparam logic [7:0] ST_GOOD = 8'h01;

    typedef enum logic [1:0] {S_IDLE, S_CHECK, S_DATA, S_HDR} seq_st_t;

    // Ring successor of a page: increment, fold to start at stop.
    function automatic logic [PG_W-1:0] ring_next(input logic [PG_W-1:0] p,
                                                  input logic [PG_W-1:0] s,
                                                  input logic [PG_W-1:0] e);
        logic [PG_W-1:0] n;
        n = p + 1'b1;
        return (n == e) ? s : n;
    endfunction

    // Header byte k: status, next page, length low, length high.
    function automatic logic [7:0] hdr_byte(input logic [1:0]  k,
                                            input logic [7:0]  nxt,
                                            input logic [15:0] tot);
        case (k)
            2'd0:    return ST_GOOD;
            2'd1:    return nxt;
            2'd2:    return tot[7:0];
            default: return tot[15:8];
        endcase
    endfunction
endpackage

// File: rtl/rxr_page_ptr.sv
module rxr_page_ptr
    import rxr_pkg::*;
#(
    parameter int PGW = PG_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_ld,
    input  logic [PGW-1:0] host_val,
    input  logic           adv,
    input  logic           restore,
    input  logic [PGW-1:0] restore_val,
    input  logic [PGW-1:0] pstart,
    input  logic [PGW-1:0] pstop,
    output logic [PGW-1:0] cur
);
    always_ff @(posedge clk) begin
        if (rst)          cur <= '0;
        else if (restore) cur <= restore_val;
        else if (adv)     cur <= ring_next(cur, pstart, pstop);
        else if (host_ld) cur <= host_val;
    end

    // R3: finishing the last page before stop folds to start
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && !restore && (PGW'(cur + 1'b1) == pstop)) |=> (cur == $past(pstart)));

    // R3: an ordinary advance moves by exactly one page
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && !restore && (PGW'(cur + 1'b1) != pstop)) |=> (cur == PGW'($past(cur) + 1'b1)));
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
    import rxr_pkg::*;
#(
    parameter int PGW  = PG_W,
    parameter int OFFW = OFF_W,
    parameter int AW   = MEM_AW,
    parameter int LW   = LEN_W,
    parameter int HDR  = HDR_LEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stopped,
    input  logic           frm_valid,
    input  logic [LW-1:0]  frm_len,
    input  logic           host_ld,
    input  logic [PGW-1:0] host_val,
    input  logic [PGW-1:0] cur,
    input  logic [PGW-1:0] bound,
    input  logic [7:0]     dat_byte,
    output logic           adv,
    output logic           restore,
    output logic [PGW-1:0] first_pg,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    output logic           dat_req,
    output logic [LW-1:0]  dat_idx,
    output logic           busy,
    output logic           rx_ok,
    output logic           ovr,
    output logic [7:0]     rsr
);
    localparam int HCW = $clog2(HDR);
    localparam int FAW = PGW + OFFW;

    seq_st_t        st;
    logic [LW-1:0]  len_q, tot_q, idx_q;
    logic [OFFW-1:0] off_q;
    logic [HCW-1:0] hcnt;
    logic [PGW-1:0] first_q;
    logic           rx_ok_q, ovr_q;
    logic [7:0]     rsr_q;
    logic [FAW-1:0] full_addr;

    logic accept, hit, last_byte, page_end, hdr_last;
    assign accept    = (st == S_IDLE) && frm_valid && !stopped;
    assign hit       = (cur == bound);
    assign last_byte = (idx_q == len_q - LW'(1));
    assign page_end  = (off_q == '1);
    assign hdr_last  = (hcnt == HCW'(HDR - 1));

    always_comb begin
        adv       = 1'b0;
        restore   = 1'b0;
        mem_we    = 1'b0;
        dat_req   = 1'b0;
        full_addr = '0;
        mem_wdata = '0;
        case (st)
            S_CHECK: begin
                restore = hit;
                adv     = !hit && (len_q == '0);
            end
            S_DATA: begin
                mem_we    = 1'b1;
                dat_req   = 1'b1;
                full_addr = {cur, off_q};
                mem_wdata = dat_byte;
                adv       = last_byte || page_end;
            end
            S_HDR: begin
                mem_we    = 1'b1;
                full_addr = {first_q, {(OFFW-HCW){1'b0}}, hcnt};
                mem_wdata = hdr_byte(hcnt, cur, tot_q);
            end
            default: ;
        endcase
    end

    assign mem_addr = full_addr[AW-1:0];
    assign dat_idx  = idx_q;
    assign first_pg = first_q;
    assign busy     = (st != S_IDLE);
    assign rx_ok    = rx_ok_q;
    assign ovr      = ovr_q;
    assign rsr      = rsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            len_q   <= '0;
            tot_q   <= '0;
            idx_q   <= '0;
            off_q   <= '0;
            hcnt    <= '0;
            first_q <= '0;
            rx_ok_q <= 1'b0;
            ovr_q   <= 1'b0;
            rsr_q   <= '0;
        end else begin
            rx_ok_q <= 1'b0;
            ovr_q   <= 1'b0;
            case (st)
                S_IDLE: if (accept) begin
                    len_q   <= frm_len;
                    tot_q   <= frm_len + LW'(HDR);
                    first_q <= host_ld ? host_val : cur;
                    off_q   <= OFFW'(HDR);
                    idx_q   <= '0;
                    st      <= S_CHECK;
                end
                S_CHECK: begin
                    hcnt <= '0;
                    if (hit) begin
                        ovr_q <= 1'b1;
                        st    <= S_IDLE;
                    end else if (len_q == '0) st <= S_HDR;
                    else                      st <= S_DATA;
                end
                S_DATA: begin
                    idx_q <= idx_q + LW'(1);
                    off_q <= off_q + OFFW'(1);
                    if (last_byte)     st <= S_HDR;
                    else if (page_end) st <= S_CHECK;
                end
                S_HDR: begin
                    hcnt <= hcnt + HCW'(1);
                    if (hdr_last) begin
                        rx_ok_q <= 1'b1;
                        rsr_q   <= ST_GOOD;
                        st      <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R6: the two outcome pulses exclude each other
    p_evt_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_ok, ovr}));
    // R6: an abandon leaves the block idle with the pointer on the first page
    p_ovr_idle_r6: assert property (@(posedge clk) disable iff (rst)
        ovr |-> (!busy && cur == first_q));
    // R5: receive-ok follows a write cycle of the same frame
    p_ok_after_hdr_r5: assert property (@(posedge clk) disable iff (rst)
        rx_ok |-> ($past(mem_we) && !busy));
    // R11: status value present together with the pulse
    p_rsr_r11: assert property (@(posedge clk) disable iff (rst)
        rx_ok |-> (rsr == ST_GOOD));
    // R7: no start while stopped
    p_stop_block_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && stopped) |=> !busy);
    // R2: nothing reaches memory outside a frame
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !mem_we);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stopped,
    input  logic [PG_W-1:0]   pg_start,
    input  logic [PG_W-1:0]   pg_stop,
    input  logic [PG_W-1:0]   pg_bound,
    input  logic              cur_wr_en,
    input  logic [PG_W-1:0]   cur_wr_val,
    output logic [PG_W-1:0]   cur_page,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              dat_req,
    output logic [LEN_W-1:0]  dat_idx,
    input  logic [7:0]        dat_byte,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              rx_ok,
    output logic              ovr,
    output logic [7:0]        rsr
);
    logic            host_ld, adv, restore;
    logic [PG_W-1:0] first_pg;

    assign host_ld = cur_wr_en && !busy;

    rxr_page_ptr #(.PGW(PG_W)) u_ptr (
        .clk(clk), .rst(rst),
        .host_ld(host_ld), .host_val(cur_wr_val),
        .adv(adv), .restore(restore), .restore_val(first_pg),
        .pstart(pg_start), .pstop(pg_stop),
        .cur(cur_page)
    );

    rxr_seq #(.PGW(PG_W), .OFFW(OFF_W), .AW(MEM_AW), .LW(LEN_W), .HDR(HDR_LEN)) u_seq (
        .clk(clk), .rst(rst), .stopped(stopped),
        .frm_valid(frm_valid), .frm_len(frm_len),
        .host_ld(host_ld), .host_val(cur_wr_val),
        .cur(cur_page), .bound(pg_bound), .dat_byte(dat_byte),
        .adv(adv), .restore(restore), .first_pg(first_pg),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .dat_req(dat_req), .dat_idx(dat_idx),
        .busy(busy), .rx_ok(rx_ok), .ovr(ovr), .rsr(rsr)
    );
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, stopped, cur_wr_en, frm_valid;
    logic [7:0]  pg_start, pg_stop, pg_bound, cur_wr_val, cur_page;
    logic [15:0] frm_len, dat_idx;
    logic        dat_req, mem_we, busy, rx_ok, ovr;
    logic [7:0]  dat_byte, mem_wdata, rsr;
    logic [14:0] mem_addr;

    function automatic logic [7:0] dat_fn(input int i);
        return 8'(i) ^ 8'((i >> 8) * 37) ^ 8'h5A;
    endfunction
    assign dat_byte = dat_fn(int'(dat_idx));

    rx_ring_writer uut (
        .clk(clk), .rst(rst), .stopped(stopped),
        .pg_start(pg_start), .pg_stop(pg_stop), .pg_bound(pg_bound),
        .cur_wr_en(cur_wr_en), .cur_wr_val(cur_wr_val), .cur_page(cur_page),
        .frm_valid(frm_valid), .frm_len(frm_len),
        .dat_req(dat_req), .dat_idx(dat_idx), .dat_byte(dat_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .rx_ok(rx_ok), .ovr(ovr), .rsr(rsr)
    );

    typedef struct {
        bit busy; bit we; int addr; int data; bit ok; bit ov; int tg;
    } rec_t;

    rec_t q[$];
    int   checks = 0, errors = 0;
    int   cur_m = 0, rsr_m = 0;
    bit   busy_m = 0;

    function automatic string tname(input int t);
        case (t)
            2:  return "R2";
            4:  return "R4";
            10: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tg, act, exp, $time);
        end
    endtask

    function automatic int nxt(input int p);
        int n;
        n = (p + 1) & 255;
        return (n == int'(pg_stop)) ? int'(pg_start) : n;
    endfunction

    function automatic rec_t mk(input bit b, input bit w, input int a, input int d,
                                input bit o, input bit v, input int t);
        rec_t r;
        r.busy = b; r.we = w; r.addr = a; r.data = d; r.ok = o; r.ov = v; r.tg = t;
        return r;
    endfunction

    // Behavioural schedule of one accepted frame, one record per cycle.
    task automatic build(input int len);
        int first, pg, off, i, tot, ht;
        first = cur_m; pg = cur_m; off = 4; i = 0; tot = len + 4;
        ht = (len == 0) ? 10 : 4;
        forever begin
            q.push_back(mk(1, 0, 0, 0, 0, 0, 8));
            if (pg == int'(pg_bound)) begin       // R6 abandon
                q.push_back(mk(0, 0, 0, 0, 0, 1, 8));
                cur_m = first;
                return;
            end
            if (len == 0) begin pg = nxt(pg); break; end
            while (off < 256 && i < len) begin
                q.push_back(mk(1, 1, ((pg << 8) | off) & 32'h7FFF, int'(dat_fn(i)), 0, 0, 2));
                i++; off++;
            end
            pg = nxt(pg);                          // R3 advance / wrap
            if (i == len) break;
            off = 0;
        end
        q.push_back(mk(1, 1, (first << 8) & 32'h7FFF,       1,                 0, 0, ht));
        q.push_back(mk(1, 1, ((first << 8) | 1) & 32'h7FFF, pg,                0, 0, ht));
        q.push_back(mk(1, 1, ((first << 8) | 2) & 32'h7FFF, tot & 255,         0, 0, ht));
        q.push_back(mk(1, 1, ((first << 8) | 3) & 32'h7FFF, (tot >> 8) & 255,  0, 0, ht));
        q.push_back(mk(0, 0, 0, 0, 1, 0, 8));
        cur_m = pg;
    endtask

    // Apply the model's edge effects, wait one cycle, compare, clear pulses.
    task automatic step();
        rec_t r;
        if (cur_wr_en && !busy_m) cur_m = int'(cur_wr_val);        // R9
        if (frm_valid && !busy_m && !stopped) build(int'(frm_len)); // R7 gate
        @(negedge clk);
        if (q.size() > 0) r = q.pop_front();
        else              r = mk(0, 0, 0, 0, 0, 0, 8);
        if (r.ok) rsr_m = 1;
        chk(busy == r.busy, "R8", int'(busy), int'(r.busy));
        chk(mem_we == r.we, tname(r.tg), int'(mem_we), int'(r.we));
        if (r.we) begin
            chk(int'(mem_addr) == r.addr, tname(r.tg), int'(mem_addr), r.addr);
            chk(int'(mem_wdata) == r.data, tname(r.tg), int'(mem_wdata), r.data);
        end
        chk(rx_ok == r.ok, "R5", int'(rx_ok), int'(r.ok));
        chk(ovr == r.ov, "R6", int'(ovr), int'(r.ov));
        chk(int'(rsr) == rsr_m, "R11", int'(rsr), rsr_m);
        if (!r.busy) chk(int'(cur_page) == cur_m, "R3", int'(cur_page), cur_m);
        busy_m = r.busy;
        frm_valid = 1'b0;
        cur_wr_en = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) step();
        step();
    endtask

    task automatic send(input int len);
        frm_len = 16'(len); frm_valid = 1'b1;
        step();
        drain();
    endtask

    task automatic load(input int v);
        cur_wr_val = 8'(v); cur_wr_en = 1'b1;
        step();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; stopped = 1'b0; cur_wr_en = 1'b0; frm_valid = 1'b0;
        cur_wr_val = '0; frm_len = '0;
        pg_start = 8'h40; pg_stop = 8'h48; pg_bound = 8'h3F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy,  "R1", int'(busy), 0);
        chk(!mem_we, "R1", int'(mem_we), 0);
        chk(cur_page == 8'h00, "R1", int'(cur_page), 0);
        chk(rsr == 8'h00 && !rx_ok && !ovr, "R1", int'(rsr), 0);

        load(8'h40);
        send(10);          // one page, R2 R4 R5
        send(252);         // last byte at offset 255
        send(600);         // three pages
        send(800);         // wraps past stop to start, R3
        chk(int'(cur_page) == 8'h41, "R3", int'(cur_page), 8'h41);

        // R6: wrap lands on the boundary page
        pg_bound = 8'h40;
        send(2000);
        chk(int'(cur_page) == 8'h41, "R6", int'(cur_page), 8'h41);
        // R6: boundary on the very first page
        pg_bound = 8'h41;
        send(30);
        chk(int'(cur_page) == 8'h41, "R6", int'(cur_page), 8'h41);
        pg_bound = 8'h3F;

        // R7: stopped refuses the request
        stopped = 1'b1;
        frm_len = 16'd20; frm_valid = 1'b1;
        step();
        step();
        chk(!busy && !mem_we, "R7", int'(busy), 0);
        stopped = 1'b0;

        send(0);           // R10 header only

        // R8 R9: requests and loads while busy are ignored
        frm_len = 16'd300; frm_valid = 1'b1;
        step();
        step();
        frm_len = 16'd5; frm_valid = 1'b1; cur_wr_val = 8'h47; cur_wr_en = 1'b1;
        step();
        drain();
        chk(int'(cur_page) == 8'h44, "R9", int'(cur_page), 8'h44);

        // R9: load coinciding with acceptance places the frame at the loaded page
        cur_wr_val = 8'h46; cur_wr_en = 1'b1;
        frm_len = 16'd20; frm_valid = 1'b1;
        step();
        drain();
        chk(int'(cur_page) == 8'h47, "R9", int'(cur_page), 8'h47);

        send(1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule